// File: doc/BRIEF.md
# Early-Exit Signed-Digit Sign Adder

This block sums a set of signed operands that arrive one digit per cycle, highest weight first. Each digit is radix 2 and redundant: it takes a value in {-1, 0, +1}. A balanced tree of serial adders reduces the operands to one result stream. The tree's output digits are also redundant, and they come out highest weight first.

A detector watches the result stream. The first nonzero digit it sees fixes the sign of the whole sum. At that point the block raises `done`, reports the sign, stops the tree and takes no more operand digits. A run-time digit budget can end the search sooner. A run that exhausts the budget on zero digits reports a zero result. That zero means the sum lies within the truncation error. The block suits sign tests inside iterative algorithms, such as the sign of a gradient or a correlation, where the full-width sum is never needed.

A one-cycle `start` pulse begins a run. While `busy` is high, the block takes one digit per operand in each cycle. The `done`, `sign_neg` and `zero` outputs hold their values until the next `start`.

Top module: `osd_sign_adder`

## Requirements
- R1: While reset is asserted and after it is released, with no start pulse yet, `busy`, `done`, `sign_neg` and `zero` are all 0.
- R2: An operand digit is coded as the pair (`op_pos[i]`, `op_neg[i]`): 10 means +1, 01 means -1 and 00 means 0. The pair 11 is never driven while `busy` is high. Operand digit k (k = 0 .. N_DIG-1) has integer weight 2^(N_DIG-1-k) and is taken in the k-th cycle with `busy` high, counting from 0.
- R3: A `start` pulse, including one given while a run is active, makes the next cycle show `busy`=1, `done`=0, `zero`=0 and `sign_neg`=0, and begins a fresh run.
- R4: When `max_digits` is 0 or greater than N_RES = N_DIG + log2(N_OPS), the full result is examined. In that case `zero`=1 exactly when the integer sum of the operands is 0. Otherwise `zero`=0 and `sign_neg` equals (sum < 0).
- R5: When `max_digits` = M with 1 <= M < N_RES, `zero`=1 is reported only if |sum| < 2^(N_RES-M). Whenever `zero`=0, `sign_neg` equals (sum < 0) and the sum is nonzero.
- R6: `done` rises no more than 2*log2(N_OPS) + M cycles with `busy` high after the start pulse, where M is the effective budget. A run that ends with `zero`=1 takes exactly that many cycles. `busy` falls in the same cycle that `done` rises.
- R7: After `done`, the values of `done`, `sign_neg` and `zero` hold and `busy` stays 0 until the next `start`, whatever the operand and `max_digits` inputs do.
- R8: Operand digits presented in busy cycles at or beyond index N_DIG have no effect on the reported result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| start | input | 1 | One-cycle pulse that clears the state and begins a run |
| max_digits | input | $clog2(N_RES+1) | Result-digit budget, sampled at start; 0 selects the full length |
| op_pos | input | N_OPS | Per-operand digit, positive flag |
| op_neg | input | N_OPS | Per-operand digit, negative flag |
| busy | output | 1 | High while operand digits are being taken |
| done | output | 1 | Sign decided or budget used up; holds until the next start |
| sign_neg | output | 1 | 1 when the decided sign is negative |
| zero | output | 1 | 1 when no nonzero result digit appeared within the budget |

## Verification
The checker assumes that the operand lanes never carry the illegal pair 11 while `busy` is high. It also assumes that `start` is a clean single-cycle pulse and not held over a run. The bench keeps to this by building every operand digit from the set {-1, 0, +1}. The same holds for the filler digits it drives after the operand length and while the block is idle. Its start pulses are one cycle long. A restart in the middle of a run is also a one-cycle pulse.

// File: rtl/osd_pkg.sv
package osd_pkg;

  // Redundant radix-2 digit: pos=1 -> +1, neg=1 -> -1, both 0 -> 0.
  typedef struct packed {
    logic pos;
    logic neg;
  } sd_t;

  // Sum of two digits, range -2 .. +2.
  typedef logic signed [2:0] sd_sum_t;

  // Transfer digit to the next-higher weight plus the residue kept here.
  typedef struct packed {
    sd_t t;
    sd_t w;
  } split_t;

  localparam sd_t SD_ZERO = 2'b00;
  localparam sd_t SD_PLUS = 2'b10;
  localparam sd_t SD_MINUS = 2'b01;

  function automatic sd_sum_t sd_value(sd_t d);
    sd_sum_t v;
    if (d.pos && !d.neg)      v = 3'sd1;
    else if (d.neg && !d.pos) v = -3'sd1;
    else                      v = 3'sd0;
    return v;
  endfunction

  function automatic sd_t sd_encode(sd_sum_t v);
    sd_t d;
    if (v > 3'sd0)      d = SD_PLUS;
    else if (v < 3'sd0) d = SD_MINUS;
    else                d = SD_ZERO;
    return d;
  endfunction

  // Split a position sum using the next-lower position sum as lookahead,
  // so that residue plus incoming transfer never leaves {-1,0,+1}.
  function automatic split_t sd_split(sd_sum_t cur, sd_sum_t nxt);
    split_t r;
    r.t = SD_ZERO;
    r.w = SD_ZERO;
    case (cur)
      3'sd2:  r.t = SD_PLUS;
      -3'sd2: r.t = SD_MINUS;
      3'sd1: begin
        if (nxt >= 3'sd0) begin
          r.t = SD_PLUS;
          r.w = SD_MINUS;
        end else begin
          r.w = SD_PLUS;
        end
      end
      -3'sd1: begin
        if (nxt <= 3'sd0) begin
          r.t = SD_MINUS;
          r.w = SD_PLUS;
        end else begin
          r.w = SD_MINUS;
        end
      end
      default: begin
        r.t = SD_ZERO;
        r.w = SD_ZERO;
      end
    endcase
    return r;
  endfunction

endpackage

// File: rtl/osd_level.sv
// One serial signed-digit adder: two input streams in, one stream out,
// highest weight first. The output carries one extra leading digit.
module osd_level
  import osd_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic en,
  input  sd_t  a,
  input  sd_t  b,
  output sd_t  z
);

  sd_sum_t s_q, s_d;
  sd_t     w_q, w_d;
  sd_t     z_q, z_d;
  sd_sum_t s_now;
  split_t  sp;
  logic    upd;

  assign s_now = sd_value(a) + sd_value(b);
  assign sp    = sd_split(s_q, s_now);
  assign upd   = clr | en;

  always_comb begin
    if (clr) begin
      s_d = '0;
      w_d = SD_ZERO;
      z_d = SD_ZERO;
    end else begin
      s_d = s_now;
      w_d = sp.w;
      z_d = sd_encode(sd_value(w_q) + sd_value(sp.t));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s_q <= '0;
      w_q <= SD_ZERO;
      z_q <= SD_ZERO;
    end else if (upd) begin
      s_q <= s_d;
      w_q <= w_d;
      z_q <= z_d;
    end
  end

  assign z = z_q;

endmodule

// File: rtl/osd_tree.sv
// Balanced reduction tree of serial adders in heap order: node 0 is the root,
// node i has children 2i+1 and 2i+2, leaves occupy N_OPS-1 .. 2*N_OPS-2.
module osd_tree
  import osd_pkg::*;
#(
  parameter int N_OPS = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              en,
  input  sd_t [N_OPS-1:0]   leaf,
  output sd_t               root
);

  localparam int N_NODES = 2 * N_OPS - 1;

  sd_t node [N_NODES];

  for (genvar g = 0; g < N_OPS; g++) begin : g_leaf
    assign node[N_OPS - 1 + g] = leaf[g];
  end

  for (genvar n = 0; n < N_OPS - 1; n++) begin : g_add
    osd_level add_i (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (clr),
      .en    (en),
      .a     (node[2 * n + 1]),
      .b     (node[2 * n + 2]),
      .z     (node[n])
    );
  end

  assign root = node[0];

endmodule

// File: rtl/osd_ctrl.sv
// Run control: cycle counter, operand-length mask, digit budget,
// first-nonzero sign detection and the held status triple.
module osd_ctrl
  import osd_pkg::*;
#(
  parameter int N_DIG  = 16,
  parameter int LEVELS = 2,
  localparam int FILL   = 2 * LEVELS,
  localparam int N_RES  = N_DIG + LEVELS,
  localparam int MAXD_W = $clog2(N_RES + 1),
  localparam int CNT_W  = $clog2(FILL + N_RES + 1) + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [MAXD_W-1:0] max_digits,
  input  sd_t               root,
  output logic              tree_en,
  output logic              tree_clr,
  output logic              digit_live,
  output logic              busy,
  output logic              done,
  output logic              sign_neg,
  output logic              zero
);

  logic              run_q, run_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [MAXD_W-1:0] lim_q, lim_d;
  logic              done_q, done_d;
  logic              neg_q, neg_d;
  logic              zero_q, zero_d;

  logic [MAXD_W-1:0] lim_start;
  logic [CNT_W-1:0]  last_cnt;
  logic              fill_reached;
  logic              root_nz;
  logic              upd;

  assign lim_start = ((max_digits == '0) || (max_digits > MAXD_W'(N_RES)))
                   ? MAXD_W'(N_RES) : max_digits;
  assign last_cnt     = CNT_W'(FILL) + CNT_W'(lim_q) - CNT_W'(1);
  assign fill_reached = (cnt_q >= CNT_W'(FILL));
  assign root_nz      = root.pos ^ root.neg;
  assign upd          = start | run_q;

  always_comb begin
    run_d  = run_q;
    cnt_d  = cnt_q;
    lim_d  = lim_q;
    done_d = done_q;
    neg_d  = neg_q;
    zero_d = zero_q;
    if (start) begin
      run_d  = 1'b1;
      cnt_d  = '0;
      lim_d  = lim_start;
      done_d = 1'b0;
      neg_d  = 1'b0;
      zero_d = 1'b0;
    end else if (run_q) begin
      cnt_d = cnt_q + CNT_W'(1);
      if (fill_reached && root_nz) begin
        run_d  = 1'b0;
        done_d = 1'b1;
        neg_d  = root.neg;
      end else if (cnt_q == last_cnt) begin
        run_d  = 1'b0;
        done_d = 1'b1;
        zero_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      cnt_q  <= '0;
      lim_q  <= '0;
      done_q <= 1'b0;
      neg_q  <= 1'b0;
      zero_q <= 1'b0;
    end else if (upd) begin
      run_q  <= run_d;
      cnt_q  <= cnt_d;
      lim_q  <= lim_d;
      done_q <= done_d;
      neg_q  <= neg_d;
      zero_q <= zero_d;
    end
  end

  assign tree_en    = run_q;
  assign tree_clr   = start;
  assign digit_live = run_q && (cnt_q < CNT_W'(N_DIG));
  assign busy       = run_q;
  assign done       = done_q;
  assign sign_neg   = neg_q;
  assign zero       = zero_q;

endmodule

// File: rtl/osd_sign_adder.sv
module osd_sign_adder
  import osd_pkg::*;
#(
  parameter int N_OPS = 4,
  parameter int N_DIG = 16,
  localparam int LEVELS = $clog2(N_OPS),
  localparam int N_RES  = N_DIG + LEVELS,
  localparam int MAXD_W = $clog2(N_RES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [MAXD_W-1:0] max_digits,
  input  logic [N_OPS-1:0]  op_pos,
  input  logic [N_OPS-1:0]  op_neg,
  output logic              busy,
  output logic              done,
  output logic              sign_neg,
  output logic              zero
);

  sd_t [N_OPS-1:0] leaf;
  sd_t             root_sd;
  logic            tree_en;
  logic            tree_clr;
  logic            digit_live;

  // Digits past the operand length, or outside a run, enter as zero (R8).
  for (genvar g = 0; g < N_OPS; g++) begin : g_lane
    assign leaf[g] = digit_live ? sd_t'({op_pos[g], op_neg[g]}) : SD_ZERO;
  end

  osd_tree #(.N_OPS(N_OPS)) tree_i (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (tree_clr),
    .en    (tree_en),
    .leaf  (leaf),
    .root  (root_sd)
  );

  osd_ctrl #(.N_DIG(N_DIG), .LEVELS(LEVELS)) ctrl_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .max_digits (max_digits),
    .root       (root_sd),
    .tree_en    (tree_en),
    .tree_clr   (tree_clr),
    .digit_live (digit_live),
    .busy       (busy),
    .done       (done),
    .sign_neg   (sign_neg),
    .zero       (zero)
  );

endmodule

// File: rtl/osd_sign_adder_chk.sv
module osd_sign_adder_chk #(
  parameter int N_OPS = 4,
  parameter int N_DIG = 16,
  localparam int LEVELS = $clog2(N_OPS),
  localparam int FILL   = 2 * LEVELS,
  localparam int N_RES  = N_DIG + LEVELS,
  localparam int MAXD_W = $clog2(N_RES + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic [MAXD_W-1:0] max_digits,
  input logic [N_OPS-1:0]  op_pos,
  input logic [N_OPS-1:0]  op_neg,
  input logic              busy,
  input logic              done,
  input logic              sign_neg,
  input logic              zero
);

  int lim_q;
  int run_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lim_q   <= 0;
      run_cnt <= 0;
    end else if (start) begin
      lim_q   <= ((max_digits == '0) || (int'(max_digits) > N_RES)) ? N_RES : int'(max_digits);
      run_cnt <= 0;
    end else if (busy) begin
      run_cnt <= run_cnt + 1;
    end
  end

  assert_legal_ops_R2: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> ((op_pos & op_neg) == '0))
    else $error("illegal operand digit pair while busy");

  assert_start_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (busy && !done && !zero && !sign_neg))
    else $error("start did not clear status");

  assert_busy_ends_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> (!busy && $past(busy)))
    else $error("done rose without busy falling");

  assert_done_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (run_cnt < FILL + lim_q))
    else $error("run exceeded digit budget");

  assert_hold_status_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!start && done) |=> (done && $stable(sign_neg) && $stable(zero)))
    else $error("status changed without start");

  assert_idle_stays_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!start && !busy) |=> !busy)
    else $error("busy rose without start");

endmodule

bind osd_sign_adder osd_sign_adder_chk #(.N_OPS(N_OPS), .N_DIG(N_DIG)) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .start      (start),
  .max_digits (max_digits),
  .op_pos     (op_pos),
  .op_neg     (op_neg),
  .busy       (busy),
  .done       (done),
  .sign_neg   (sign_neg),
  .zero       (zero)
);

// File: tb/osd_sign_adder_tb.sv
`timescale 1ns/1ps
module osd_sign_adder_tb_top;

  localparam int N_OPS  = 4;
  localparam int N_DIG  = 16;
  localparam int LEVELS = $clog2(N_OPS);
  localparam int FILL   = 2 * LEVELS;
  localparam int N_RES  = N_DIG + LEVELS;
  localparam int MAXD_W = $clog2(N_RES + 1);
  localparam int GUARD  = FILL + N_RES + 8;

  logic              clk;
  logic              rst_n;
  logic              start;
  logic [MAXD_W-1:0] max_digits;
  logic [N_OPS-1:0]  op_pos;
  logic [N_OPS-1:0]  op_neg;
  logic              busy;
  logic              done;
  logic              sign_neg;
  logic              zero;

  int total = 0;
  int bad   = 0;
  int dig [N_OPS][N_DIG];

  osd_sign_adder #(.N_OPS(N_OPS), .N_DIG(N_DIG)) dut_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .max_digits (max_digits),
    .op_pos     (op_pos),
    .op_neg     (op_neg),
    .busy       (busy),
    .done       (done),
    .sign_neg   (sign_neg),
    .zero       (zero)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int rand_digit();
    return int'($urandom % 3) - 1;
  endfunction

  function automatic longint ref_sum();
    longint v = 0;
    for (int o = 0; o < N_OPS; o++)
      for (int i = 0; i < N_DIG; i++)
        v += longint'(dig[o][i]) * (longint'(1) <<< (N_DIG - 1 - i));
    return v;
  endfunction

  function automatic int eff_lim(input int lim_in);
    return ((lim_in == 0) || (lim_in > N_RES)) ? N_RES : lim_in;
  endfunction

  task automatic drive_digit(input int k, input bit junk);
    for (int o = 0; o < N_OPS; o++) begin
      int d;
      if (k < N_DIG) d = dig[o][k];
      else if (junk) d = rand_digit();
      else d = 0;
      op_pos[o] = (d == 1);
      op_neg[o] = (d == -1);
    end
  endtask

  // Fill patterns: 0 uniform, 1 sparse, 2 near-cancelling pairs.
  task automatic fill_ops(input int pat);
    int keep;
    keep = N_DIG - 1 - int'($urandom % 4);
    for (int i = 0; i < N_DIG; i++) begin
      for (int o = 0; o < N_OPS; o++) begin
        if (pat == 1) dig[o][i] = (($urandom % 8) == 0) ? rand_digit() : 0;
        else          dig[o][i] = rand_digit();
      end
      if (pat == 2 && i < keep) begin
        for (int o = 1; o < N_OPS; o += 2) dig[o][i] = -dig[o-1][i];
      end
    end
  endtask

  task automatic fill_const(input int d);
    for (int o = 0; o < N_OPS; o++)
      for (int i = 0; i < N_DIG; i++) dig[o][i] = d;
  endtask

  task automatic run_case(input int lim_in, input bit junk);
    longint v;
    longint tol;
    longint mag;
    int     eff;
    int     ncyc;
    bit     fin;
    v   = ref_sum();
    eff = eff_lim(lim_in);
    tol = longint'(1) <<< (N_RES - eff);
    mag = (v < 0) ? -v : v;
    @(negedge clk);
    start      = 1'b1;
    max_digits = MAXD_W'(lim_in);
    op_pos     = '0;
    op_neg     = '0;
    @(negedge clk);
    start = 1'b0;
    // R3: fresh run state one cycle after start
    check(busy && !done && !zero && !sign_neg, "R3",
          {busy, done, zero, sign_neg}, 4'b1000);
    ncyc = 0;
    fin  = 1'b0;
    while (!fin && ncyc < GUARD) begin
      drive_digit(ncyc, junk);
      @(negedge clk);
      ncyc++;
      if (done) fin = 1'b1;
    end
    op_pos = '0;
    op_neg = '0;
    // R6: done within the fill plus the budget, busy already low
    check(fin && !busy && ncyc <= FILL + eff, "R6", ncyc, FILL + eff);
    if (zero) begin
      check(ncyc == FILL + eff, "R6", ncyc, FILL + eff);
      if (eff == N_RES) check(v == 0, "R4", v, 0);
      else              check(mag < tol, "R5", mag, tol);
    end else begin
      if (eff == N_RES) check(v != 0 && sign_neg == (v < 0), "R4", sign_neg, v < 0);
      else              check(v != 0 && sign_neg == (v < 0), "R5", sign_neg, v < 0);
    end
  endtask

  // R7: outputs hold while idle, whatever the inputs do
  task automatic idle_check();
    logic [3:0] snap;
    bit ok;
    snap = {busy, done, sign_neg, zero};
    ok   = 1'b1;
    for (int c = 0; c < 4; c++) begin
      for (int o = 0; o < N_OPS; o++) begin
        int d;
        d = rand_digit();
        op_pos[o] = (d == 1);
        op_neg[o] = (d == -1);
      end
      max_digits = MAXD_W'($urandom);
      @(negedge clk);
      if ({busy, done, sign_neg, zero} != snap) ok = 1'b0;
    end
    check(ok, "R7", {busy, done, sign_neg, zero}, snap);
    op_pos = '0;
    op_neg = '0;
  endtask

  // Partial run abandoned by a restart (R3).
  task automatic partial_run(input int k);
    @(negedge clk);
    start      = 1'b1;
    max_digits = '0;
    @(negedge clk);
    start = 1'b0;
    for (int c = 0; c < k; c++) begin
      drive_digit(c, 1'b1);
      @(negedge clk);
    end
  endtask

  initial begin
    #(4 * 150000);
    total++;
    bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n      = 1'b0;
    start      = 1'b0;
    max_digits = '0;
    op_pos     = '0;
    op_neg     = '0;
    repeat (3) @(negedge clk);
    check({busy, done, sign_neg, zero} == 4'b0000, "R1", {busy, done, sign_neg, zero}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check({busy, done, sign_neg, zero} == 4'b0000, "R1", {busy, done, sign_neg, zero}, 0);

    // All-zero operands: zero result after the whole stream (R4, R6).
    fill_const(0);
    run_case(0, 1'b0);
    idle_check();

    // Single least-significant digit, both polarities (R2, R4).
    fill_const(0);
    dig[N_OPS-1][N_DIG-1] = 1;
    run_case(0, 1'b0);
    fill_const(0);
    dig[0][N_DIG-1] = -1;
    run_case(N_RES + 3, 1'b0);

    // Extremes (R2, R4).
    fill_const(1);
    run_case(0, 1'b0);
    fill_const(-1);
    run_case(0, 1'b0);

    // Tiny sum with a one-digit budget: must truncate to zero (R5).
    fill_const(0);
    dig[1][N_DIG-1] = 1;
    run_case(1, 1'b0);

    // Junk after the operand length must not matter (R8).
    fill_const(0);
    run_case(0, 1'b1);
    fill_const(0);
    dig[2][N_DIG-2] = -1;
    run_case(0, 1'b1);

    // Restart while busy (R3).
    partial_run(5);
    fill_const(0);
    dig[0][3] = 1;
    dig[1][3] = -1;
    dig[3][N_DIG-1] = -1;
    run_case(0, 1'b0);

    for (int n = 0; n < 160; n++) begin
      int lim_sel;
      int lim_in;
      fill_ops(int'($urandom % 3));
      lim_sel = int'($urandom % 4);
      if (lim_sel == 0)      lim_in = 0;
      else if (lim_sel == 1) lim_in = N_RES + 1 + int'($urandom % 3);
      else                   lim_in = 1 + int'($urandom % N_RES);
      if ((n % 17) == 5) partial_run(1 + int'($urandom % 8));
      run_case(lim_in, ($urandom % 2) == 1);   // R4 R5 R6 R8
      if ((n % 10) == 0) idle_check();
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule